// File: doc/BRIEF.md
# Six-Mode Shift and Rotate Unit

This block moves the bits of a W-bit word (8 by default) by a variable amount. A 3-bit operation code picks one of six movements: zero-filling shifts in either direction, edge-replicating shifts in either direction, and rotations in either direction. The result is presented on a registered output one clock after the operands. All six movements share one datapath. Right-going operations reverse the word, shift it left, and reverse it back. The left shifter is a chain of log2(W) fixed-distance multiplexer stages, one per amount bit.

The edge-replicating left shift fills the vacated low positions with copies of the original least significant bit, not with zeros. The edge-replicating right shift fills the vacated high positions with copies of the original most significant bit. In a shift, an amount of W or more clears the word down to fill bits. In a rotation, only the amount modulo W matters. W must be a power of two.

Top module: `shf_unit`

## Requirements
- R1: Operation code 000 shifts left and fills the vacated low bits with 0 (10010101 by 2 gives 01010100).
- R2: Operation code 001 shifts right and fills the vacated high bits with 0 (10010101 by 3 gives 00010010).
- R3: Operation code 010 shifts left and fills the vacated low bits with the original bit 0 (10010101 by 3 gives 10101111).
- R4: Operation code 011 shifts right and fills the vacated high bits with the original bit W-1 (10010101 by 2 gives 11100101).
- R5: Operation code 100 rotates left, so bits leaving bit W-1 re-enter at bit 0 (10010101 by 3 gives 10101100).
- R6: Operation code 101 rotates right, so bits leaving bit 0 re-enter at bit W-1 (10010101 by 5 gives 10101100).
- R7: Operation codes 110 and 111 return the input word unchanged, whatever the amount.
- R8: In the four shift codes (000 to 011), an amount of W or more gives a word made only of fill bits: all zeros for 000 and 001, copies of bit 0 for 010, and copies of bit W-1 for 011.
- R9: In the two rotate codes (100, 101), the amount is taken modulo W, so an amount of W+k gives the same result as k.
- R10: An amount of zero returns the input word unchanged under every operation code.
- R11: `data_o` shows the result for the operands applied at the previous rising clock edge. A synchronous active-high `rst` sampled at an edge clears `data_o` to all zeros at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operation code (see R1 to R7) |
| amt_i | input | AMT_W | Shift or rotate distance, unsigned (default width log2(W)+1) |
| data_i | input | W | Operand word |
| data_o | output | W | Registered result |

## Verification
The bench sweeps every operation code against every amount the port can carry. For each code it uses operands whose edge bits differ: one with bit 0 set and bit W-1 clear, one the other way round, and one with both set. A fill taken from the wrong edge, or zero-filling in an edge-replicating mode, therefore shows up as wrong low or high bits. Amounts of W and above catch two kinds of fault: a shifter that drops the upper amount bits would wrap a shift instead of clearing it, and a shifter that honours those bits in a rotation would clear a rotation instead of wrapping it. The zero amount and the two spare codes catch a datapath that alters a word it should leave alone. A reset pulse in mid-run checks that the output register clears at once and not one cycle late.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    SHM_LSL = 3'b000,
    SHM_LSR = 3'b001,
    SHM_ASL = 3'b010,
    SHM_ASR = 3'b011,
    SHM_ROL = 3'b100,
    SHM_ROR = 3'b101,
    SHM_PS6 = 3'b110,
    SHM_PS7 = 3'b111
  } shf_mode_e;

  typedef struct packed {
    logic go_right;
    logic wrap;
    logic arith;
    logic pass;
  } shf_ctl_t;
endpackage

// File: rtl/shf_mode_dec.sv
module shf_mode_dec
  import shf_pkg::*;
(
  input  logic [2:0] mode,
  output shf_ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    case (shf_mode_e'(mode))
      SHM_LSL: ctl = '{go_right: 1'b0, wrap: 1'b0, arith: 1'b0, pass: 1'b0};
      SHM_LSR: ctl = '{go_right: 1'b1, wrap: 1'b0, arith: 1'b0, pass: 1'b0};
      SHM_ASL: ctl = '{go_right: 1'b0, wrap: 1'b0, arith: 1'b1, pass: 1'b0};
      SHM_ASR: ctl = '{go_right: 1'b1, wrap: 1'b0, arith: 1'b1, pass: 1'b0};
      SHM_ROL: ctl = '{go_right: 1'b0, wrap: 1'b1, arith: 1'b0, pass: 1'b0};
      SHM_ROR: ctl = '{go_right: 1'b1, wrap: 1'b1, arith: 1'b0, pass: 1'b0};
      default: ctl = '{go_right: 1'b0, wrap: 1'b0, arith: 1'b0, pass: 1'b1};
    endcase
  end
endmodule

// File: rtl/shf_bitrev.sv
module shf_bitrev #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/shf_stages.sv
module shf_stages #(
  parameter int W   = 8,
  parameter int STG = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [STG-1:0] amt,
  input  logic           wrap,
  input  logic           fill,
  output logic [W-1:0]   dout
);
  logic [W-1:0] lvl [0:STG];

  assign lvl[0] = din;

  for (genvar k = 0; k < STG; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] moved;
    assign moved = wrap ? {lvl[k][W-1-S:0], lvl[k][W-1:W-S]}
                        : {lvl[k][W-1-S:0], {S{fill}}};
    assign lvl[k+1] = amt[k] ? moved : lvl[k];
  end

  assign dout = lvl[STG];
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int W     = 8,
  parameter int AMT_W = $clog2(W) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [W-1:0]     data_i,
  output logic [W-1:0]     data_o
);
  localparam int STG = $clog2(W);

  shf_ctl_t     ctl;
  logic [W-1:0] data_rev, pre, sh_out, sh_lim, sh_rev, post, result;
  logic         fill, over;

  shf_mode_dec u_dec (.mode(mode_i), .ctl(ctl));

  shf_bitrev #(.W(W)) u_rev_in (.din(data_i), .dout(data_rev));

  assign pre  = ctl.go_right ? data_rev : data_i;
  // after the optional reversal, bit 0 is the edge a replicating shift copies
  assign fill = ctl.arith & pre[0];

  if (AMT_W > STG) begin : g_over
    assign over = |amt_i[AMT_W-1:STG];
  end else begin : g_no_over
    assign over = 1'b0;
  end

  shf_stages #(.W(W), .STG(STG)) u_stg (
    .din  (pre),
    .amt  (amt_i[STG-1:0]),
    .wrap (ctl.wrap),
    .fill (fill),
    .dout (sh_out)
  );

  assign sh_lim = (over && !ctl.wrap) ? {W{fill}} : sh_out;

  shf_bitrev #(.W(W)) u_rev_out (.din(sh_lim), .dout(sh_rev));

  assign post   = ctl.go_right ? sh_rev : sh_lim;
  assign result = ctl.pass ? data_i : post;

  always_ff @(posedge clk) begin
    if (rst) data_o <= '0;
    else     data_o <= result;
  end
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
  parameter int W     = 8,
  parameter int AMT_W = $clog2(W) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       mode_i,
  input logic [AMT_W-1:0] amt_i,
  input logic [W-1:0]     data_i,
  input logic [W-1:0]     data_o
);
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> data_o == '0);

  // R10
  zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
    (amt_i == '0) |=> data_o == $past(data_i));

  // R7
  spare_code_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i[2:1] == 2'b11) |=> data_o == $past(data_i));

  // R5
  rotate_bits_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'b100 || mode_i == 3'b101)
      |=> $countones(data_o) == $countones($past(data_i)));

  // R8
  lsl_over_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'b000 && amt_i >= AMT_W'(W)) |=> data_o == '0);

  // R8
  asr_over_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'b011 && amt_i >= AMT_W'(W))
      |=> data_o == {W{$past(data_i[W-1])}});
endmodule

bind shf_unit shf_unit_chk #(.W(W), .AMT_W(AMT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .mode_i (mode_i),
  .amt_i  (amt_i),
  .data_i (data_i),
  .data_o (data_o)
);

// File: tb/shf_unit_tb.sv
module shf_unit_tb;
  localparam int W     = 8;
  localparam int AMT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       mode_i = '0;
  logic [AMT_W-1:0] amt_i = '0;
  logic [W-1:0]     data_i = '0;
  logic [W-1:0]     data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [W-1:0] exp;
    string        req;
  } item_t;

  item_t sb_q[$];

  always #10 clk = ~clk;

  shf_unit #(.W(W), .AMT_W(AMT_W)) u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .amt_i(amt_i),
    .data_i(data_i), .data_o(data_o)
  );

  function automatic logic [W-1:0] ref_model(input logic [2:0] m, input int a,
                                             input logic [W-1:0] d);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      int src;
      case (m)
        3'd0: begin src = i - a; r[i] = (src >= 0) ? d[src] : 1'b0;  end
        3'd1: begin src = i + a; r[i] = (src < W) ? d[src] : 1'b0;   end
        3'd2: begin src = i - a; r[i] = (src >= 0) ? d[src] : d[0];  end
        3'd3: begin src = i + a; r[i] = (src < W) ? d[src] : d[W-1]; end
        3'd4: r[i] = d[(i - (a % W) + W) % W];
        3'd5: r[i] = d[(i + a) % W];
        default: r[i] = d[i];
      endcase
    end
    return r;
  endfunction

  function automatic string req_of(input logic [2:0] m, input int a);
    if (m >= 3'd6) return "R7";
    if (a == 0)    return "R10";
    if (a >= W)    return (m >= 3'd4) ? "R9" : "R8";
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic drive(input logic r, input logic [2:0] m, input int a,
                       input logic [W-1:0] d, input string tag);
    item_t it;
    @(negedge clk);
    rst    = r;
    mode_i = m;
    amt_i  = AMT_W'(a);
    data_i = d;
    it.exp = r ? '0 : ref_model(m, a, d);
    it.req = (tag != "") ? tag : req_of(m, a);
    sb_q.push_back(it);
  endtask

  // monitor: one registered result per driven item, sampled mid-cycle
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (data_o !== it.exp) begin
          fails++;
          $display("FAIL %s mode=%0d amt=%0d actual=%b expected=%b",
                   it.req, mode_i, amt_i, data_o, it.exp);
        end
      end
    end
  end

  initial begin
    // R11: reset state with busy inputs
    drive(1'b1, 3'd4, 3, 8'hFF, "R11");
    drive(1'b1, 3'd2, 1, 8'h81, "R11");
    // worked examples
    drive(1'b0, 3'd0, 2, 8'b10010101, "R1");
    drive(1'b0, 3'd1, 3, 8'b10010101, "R2");
    drive(1'b0, 3'd2, 3, 8'b10010101, "R3");
    drive(1'b0, 3'd3, 2, 8'b10010101, "R4");
    drive(1'b0, 3'd4, 3, 8'b10010101, "R5");
    drive(1'b0, 3'd5, 5, 8'b10010101, "R6");
    // R11: reset in mid-run clears at once, then operation resumes
    drive(1'b1, 3'd6, 0, 8'hA5, "R11");
    drive(1'b0, 3'd7, 9, 8'hA5, "R7");
    // full sweep: every code, every amount, edge-distinct operands
    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < (1 << AMT_W); a++) begin
        drive(1'b0, 3'(m), a, 8'b01101001, "");
        drive(1'b0, 3'(m), a, 8'b10110100, "");
        drive(1'b0, 3'(m), a, 8'b10011011, "");
      end
    end
    // R9: rotate by W+k equals rotate by k (compared against model at k)
    drive(1'b0, 3'd4, W + 3, 8'b10010101, "R9");
    drive(1'b0, 3'd5, W + 5, 8'b10010101, "R9");
    drive(1'b0, 3'd0, 0, 8'h5A, "R10");
    wait (sb_q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule